// File: doc/BRIEF.md
# Serial Memory Target Protocol Engine

This block is the bus-facing half of a 256-byte memory that sits on a two-wire serial bus as a target. It runs on a fast system clock and brings the clock and data lines in through two-flop synchronisers. From those samples it finds Start and Stop conditions and collects the control byte, the word address and any write data. It answers by pulling the data line low through an open-drain enable. It never drives the line high.

One 8-bit address pointer is shared by every access and is kept from one transaction to the next. In a write, the byte after the control byte loads the pointer. Each data byte that follows goes to a separate page-buffer block, together with the address it belongs to. The low four pointer bits count up inside the page. A Stop after at least one data byte tells the buffer to start its internal write cycle. While that cycle runs, the buffer raises a busy input, and the engine stays silent so the host can poll for completion. Reads take bytes from a plain combinational memory port addressed by the pointer and shift them out MSB first. The pointer advances across the full 8-bit range and wraps from 0xFF to 0x00.

Top module: `i2c_mem_target`

## Requirements
- R1: SDA falling while SCL is high is a Start, and SDA rising while SCL is high is a Stop. Either one, at any point, abandons the byte in progress. A Start makes the engine expect a control byte. A Stop releases SDA and leaves the engine idle.
- R2: The control byte is taken MSB first as 1,0,1,0, then three select bits, then the direction bit. The engine responds only if the code matches and bits 3..1 equal `cs_sel`. Otherwise it gives no acknowledge and ignores every later bus bit until the next Start or Stop.
- R3: After each byte it accepts, the engine pulls SDA low from the following SCL fall until the SCL fall that ends the ninth clock. The host therefore reads 0 in the ninth clock.
- R4: `sda_pull` changes only while SCL is low, so the engine itself never creates a Start or a Stop.
- R5: While `wr_busy` is high, the engine acknowledges nothing, not even a matching control byte in either direction, and then goes idle.
- R6: Direction bit 0 selects a write, and the next byte loads the pointer. Each later byte produces a one-cycle `wr_valid` with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The low four pointer bits then increment and wrap inside the 16-byte page, and the upper four bits stay fixed.
- R7: `wr_commit` pulses for one cycle after a Stop that ends a write with at least one data byte. A Stop after only the address or control byte gives no pulse, and neither does a repeated Start.
- R8: The pointer is 0 after reset. Direction bit 1 makes the engine send the byte at the pointer, MSB first, starting right after its acknowledge. The pointer then advances by one.
- R9: A repeated Start after the word address keeps the loaded pointer, so a following read starts at that address.
- R10: After a read byte, a host acknowledge (SDA low in the ninth clock) makes the engine send the next byte. A missing acknowledge leaves SDA released and ends sending. During reads the pointer wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired-AND value) |
| cs_sel | input | 3 | Chip-select strap compared against control byte bits 3..1 |
| wr_busy | input | 1 | High while the internal write cycle runs |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 8 | Target address of the write byte |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | One-cycle pulse asking the buffer to start its write cycle |
| rd_addr | output | 8 | Read address (the pointer) |
| rd_data | input | 8 | Memory byte at `rd_addr`, combinational |

## Verification
Control bytes are sent with the right code and select, with a wrong select, and while busy. Only the first case may be acknowledged, and a later byte of an unselected transfer must draw no acknowledge and no write strobe. Writes cover a single byte and a four-byte burst that starts two bytes below a page end, which separates in-page wrapping from a full carry. Reads cover random, current-address and sequential access across 0xFF. A stop and a repeated start inside a partial byte show that the pointer is not loaded from a byte that was cut short.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // fixed device-type code carried in the top nibble of the control byte
  localparam logic [3:0] TGT_TYPE_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,   // ignoring the bus until the next Start or Stop
    ST_CTRL,   // shifting in the control byte
    ST_ADDR,   // shifting in the word address
    ST_WDAT,   // shifting in write data
    ST_ACKW,   // byte accepted, waiting for SCL low to pull SDA
    ST_ACK,    // holding the acknowledge through the ninth clock
    ST_RDAT,   // shifting out a read byte
    ST_RACK    // listening for the host acknowledge
  } tgt_state_e;

endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int unsigned     W       = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tgt_bus_cond.sv
module tgt_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_q,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // SCL held high across the sample pair: any SDA move is a bus condition
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic              wr_busy,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned CODE_W = DATA_W - CS_W - 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

  // ---- arithmetic kept in functions ----
  function automatic logic ctrl_match(input logic [DATA_W-1:0] b,
                                      input logic [CS_W-1:0]   cs);
    return (b[DATA_W-1 -: CODE_W] == TGT_TYPE_CODE[CODE_W-1:0]) &&
           (b[CS_W:1] == cs);
  endfunction

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:PAGE_W], p[PAGE_W-1:0] + 1'b1};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // ---- line conditioning ----
  logic [1:0] line_s;
  logic scl_s, sda_s, scl_q;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  tgt_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  tgt_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .scl_q(scl_q),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  // ---- engine state ----
  tgt_state_e        state, ack_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-2:0] tx_sh;
  logic [ADDR_W-1:0] ptr;
  logic              host_ack;
  logic              wrote_any;

  // named internal events
  logic              in_rx, ev_byte_in, ev_ctrl_done, ev_wr_byte, ctrl_hit;
  logic [DATA_W-1:0] rx_byte;

  assign rx_byte      = {rx_sh, sda_s};
  assign in_rx        = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WDAT);
  assign ev_byte_in   = ev_rise && in_rx && (bit_cnt == LAST_BIT);
  assign ev_ctrl_done = ev_byte_in && (state == ST_CTRL);
  assign ev_wr_byte   = ev_byte_in && (state == ST_WDAT);
  assign ctrl_hit     = ctrl_match(rx_byte, cs_sel) && !wr_busy;
  assign rd_addr      = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      host_ack  <= 1'b0;
      wrote_any <= 1'b0;
      sda_pull  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (ev_start) begin
        state     <= ST_CTRL;
        bit_cnt   <= '0;
        sda_pull  <= 1'b0;
        wrote_any <= 1'b0;
      end else if (ev_stop) begin
        state     <= ST_IDLE;
        sda_pull  <= 1'b0;
        wr_commit <= wrote_any;
        wrote_any <= 1'b0;
      end else begin
        unique case (state)
          ST_CTRL, ST_ADDR, ST_WDAT: begin
            if (ev_rise) begin
              rx_sh   <= rx_byte[DATA_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                if (state == ST_CTRL) begin
                  if (ctrl_hit) begin
                    state    <= ST_ACKW;
                    ack_next <= rx_byte[0] ? ST_RDAT : ST_ADDR;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_ADDR) begin
                  ptr      <= rx_byte;
                  state    <= ST_ACKW;
                  ack_next <= ST_WDAT;
                end else begin
                  wr_valid  <= 1'b1;
                  wr_addr   <= ptr;
                  wr_data   <= rx_byte;
                  ptr       <= page_next(ptr);
                  wrote_any <= 1'b1;
                  state     <= ST_ACKW;
                  ack_next  <= ST_WDAT;
                end
              end
            end
          end
          ST_ACKW: begin
            if (ev_fall) begin
              sda_pull <= 1'b1;
              state    <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (ev_fall) begin
              bit_cnt <= '0;
              if (ack_next == ST_RDAT) begin
                tx_sh    <= rd_data[DATA_W-2:0];
                sda_pull <= ~rd_data[DATA_W-1];
                ptr      <= seq_next(ptr);
                state    <= ST_RDAT;
              end else begin
                sda_pull <= 1'b0;
                state    <= ack_next;
              end
            end
          end
          ST_RDAT: begin
            if (ev_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev_fall) begin
              if (bit_cnt == ALL_BITS) begin
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
                state    <= ST_RACK;
              end else begin
                sda_pull <= ~tx_sh[DATA_W-2];
                tx_sh    <= {tx_sh[DATA_W-3:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (ev_rise) begin
              host_ack <= ~sda_s;
            end else if (ev_fall) begin
              if (host_ack) begin
                tx_sh    <= rd_data[DATA_W-2:0];
                sda_pull <= ~rd_data[DATA_W-1];
                ptr      <= seq_next(ptr);
                bit_cnt  <= '0;
                state    <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---- assertions ----
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == ST_CTRL && bit_cnt == '0 && !sda_pull)); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == ST_IDLE && !sda_pull)); // R1
  AST_PULL_HOLDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !ev_start && !ev_stop) |=> $stable(sda_pull)); // R4
  AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ctrl_done && wr_busy) |=> (state == ST_IDLE && !sda_pull)); // R5
  AST_WRITE_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_byte |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R6
  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop)); // R7
endmodule

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b1;
  logic h_sda = 1'b1;
  logic [2:0] cs_sel = 3'b101;
  logic wr_busy;
  logic sda_pull, wr_valid, wr_commit;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_line;

  always #5 clk = ~clk;

  assign sda_line = h_sda & ~sda_pull;

  i2c_mem_target dut (
    .clk(clk), .rst_n(rst_n), .scl_in(h_scl), .sda_in(sda_line),
    .cs_sel(cs_sel), .wr_busy(wr_busy), .sda_pull(sda_pull),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ---- memory and page-buffer model ----
  logic [7:0]  mem [256];
  logic [15:0] pend_q [$];
  int          busy_cnt;
  int          n_commit;
  assign rd_data = mem[rd_addr];
  assign wr_busy = (busy_cnt != 0);

  // ---- scoreboard ----
  int          n_chk, n_bad;
  bit          finished;
  string       exp_req_q [$];
  logic [7:0]  exp_val_q [$];
  logic [7:0]  act_val_q [$];
  string       wexp_req_q [$];
  logic [15:0] wexp_val_q [$];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(string req, logic [7:0] v);
    exp_req_q.push_back(req);
    exp_val_q.push_back(v);
  endtask

  task automatic expect_wr(string req, logic [7:0] a, logic [7:0] d);
    wexp_req_q.push_back(req);
    wexp_val_q.push_back({a, d});
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      busy_cnt <= 0;
      n_commit <= 0;
    end else begin
      while (act_val_q.size() != 0) begin
        logic [7:0] a;
        a = act_val_q.pop_front();
        if (exp_val_q.size() == 0) chk("R2", "unexpected bus item", {8'h0, a}, 16'hxxxx);
        else chk(exp_req_q.pop_front(), "bus item", {8'h0, a}, {8'h0, exp_val_q.pop_front()});
      end
      if (wr_valid) begin
        pend_q.push_back({wr_addr, wr_data});
        if (wexp_val_q.size() == 0) chk("R2", "unexpected write", {wr_addr, wr_data}, 16'hxxxx);
        else chk(wexp_req_q.pop_front(), "write strobe", {wr_addr, wr_data}, wexp_val_q.pop_front());
      end
      if (wr_commit) begin
        n_commit <= n_commit + 1;
        while (pend_q.size() != 0) begin
          logic [15:0] w;
          w = pend_q.pop_front();
          mem[w[15:8]] <= w[7:0];
        end
        busy_cnt <= 1000;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  // ---- host driver ----
  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    h_sda = 1'b1; wq(5); h_scl = 1'b1; wq(10);
    h_sda = 1'b0; wq(10); h_scl = 1'b0; wq(5);
  endtask

  task automatic bus_stop;
    h_sda = 1'b0; wq(5); h_scl = 1'b1; wq(10);
    h_sda = 1'b1; wq(10);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      h_sda = b[i]; wq(5); h_scl = 1'b1; wq(10); h_scl = 1'b0; wq(5);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    send_bits(b, 8);
    h_sda = 1'b1; wq(5); h_scl = 1'b1; wq(5);
    act_val_q.push_back({7'b0, sda_line});
    wq(5); h_scl = 1'b0; wq(5);
  endtask

  task automatic recv_byte(bit give_ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      h_sda = 1'b1; wq(5); h_scl = 1'b1; wq(5);
      b[i] = sda_line; wq(5); h_scl = 1'b0; wq(5);
    end
    act_val_q.push_back(b);
    h_sda = give_ack ? 1'b0 : 1'b1; wq(5); h_scl = 1'b1; wq(10);
    h_scl = 1'b0; wq(5); h_sda = 1'b1;
  endtask

  task automatic wait_idle;
    while (wr_busy) @(negedge clk);
    wq(20);
  endtask

  localparam logic [7:0] CW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR = 8'hAB;  // 1010_101_1

  initial begin
    wq(5); rst_n = 1'b1; wq(5);
    // reset state
    chk("R1", "pull after reset", {15'h0, sda_pull}, 16'h0);
    chk("R8", "pointer after reset", {8'h0, rd_addr}, 16'h0000);

    // R2: wrong select bits, then a later byte is ignored
    bus_start;
    expect_bus("R2", 8'h01); send_byte(8'hA8);
    expect_bus("R2", 8'h01); send_byte(8'h00);
    bus_stop;
    // R2: wrong type code
    bus_start;
    expect_bus("R2", 8'h01); send_byte(8'h2A);
    bus_stop;

    // R6 R3: single byte write
    bus_start;
    expect_bus("R3", 8'h00); send_byte(CW);
    expect_bus("R3", 8'h00); send_byte(8'h23);
    expect_wr("R6", 8'h23, 8'h9C);
    expect_bus("R3", 8'h00); send_byte(8'h9C);
    bus_stop; wq(4);
    chk("R7", "commit count after byte write", 16'(n_commit), 16'd1);

    // R5: polling while busy, both directions
    bus_start; expect_bus("R5", 8'h01); send_byte(CW); bus_stop;
    bus_start; expect_bus("R5", 8'h01); send_byte(CR); bus_stop;
    wait_idle;
    bus_start; expect_bus("R5", 8'h00); send_byte(CW); bus_stop; wq(4);
    chk("R7", "no commit without data", 16'(n_commit), 16'd1);

    // R9 R8: random read of the written byte
    bus_start;
    expect_bus("R9", 8'h00); send_byte(CW);
    expect_bus("R9", 8'h00); send_byte(8'h23);
    bus_start;
    expect_bus("R9", 8'h00); send_byte(CR);
    expect_bus("R9", 8'h9C); recv_byte(1'b0);
    bus_stop; wq(4);
    chk("R7", "no commit after repeated start", 16'(n_commit), 16'd1);

    // R8: current-address read continues at 0x24
    bus_start;
    expect_bus("R8", 8'h00); send_byte(CR);
    expect_bus("R8", 8'h24 ^ 8'h5A); recv_byte(1'b0);
    bus_stop;

    // R6: burst from 0x3E wraps within the page to 0x30
    bus_start;
    expect_bus("R6", 8'h00); send_byte(CW);
    expect_bus("R6", 8'h00); send_byte(8'h3E);
    expect_wr("R6", 8'h3E, 8'h11); expect_bus("R6", 8'h00); send_byte(8'h11);
    expect_wr("R6", 8'h3F, 8'h22); expect_bus("R6", 8'h00); send_byte(8'h22);
    expect_wr("R6", 8'h30, 8'h33); expect_bus("R6", 8'h00); send_byte(8'h33);
    expect_wr("R6", 8'h31, 8'h44); expect_bus("R6", 8'h00); send_byte(8'h44);
    bus_stop; wq(4);
    chk("R7", "commit count after burst", 16'(n_commit), 16'd2);
    wait_idle;

    // R10: sequential read across 0xFF
    bus_start;
    expect_bus("R10", 8'h00); send_byte(CW);
    expect_bus("R10", 8'h00); send_byte(8'hFE);
    bus_start;
    expect_bus("R10", 8'h00); send_byte(CR);
    expect_bus("R10", 8'hFE ^ 8'h5A); recv_byte(1'b1);
    expect_bus("R10", 8'hFF ^ 8'h5A); recv_byte(1'b1);
    expect_bus("R10", 8'h00 ^ 8'h5A); recv_byte(1'b0);
    wq(2);
    chk("R10", "released after host nack", {15'h0, sda_pull}, 16'h0);
    bus_stop;

    // R1: stop inside a partial address byte keeps pointer at 0x01
    bus_start;
    expect_bus("R1", 8'h00); send_byte(CW);
    send_bits(8'h77, 4);
    bus_stop;
    bus_start;
    expect_bus("R1", 8'h00); send_byte(CR);
    expect_bus("R1", 8'h01 ^ 8'h5A); recv_byte(1'b0);
    bus_stop;
    // R1: repeated start inside a partial byte restarts the control byte
    bus_start;
    expect_bus("R1", 8'h00); send_byte(CW);
    send_bits(8'h77, 3);
    bus_start;
    expect_bus("R1", 8'h00); send_byte(CR);
    expect_bus("R1", 8'h02 ^ 8'h5A); recv_byte(1'b0);
    bus_stop;

    // R6 R10: wrapped page bytes landed at 0x30/0x31
    bus_start;
    expect_bus("R6", 8'h00); send_byte(CW);
    expect_bus("R6", 8'h00); send_byte(8'h30);
    bus_start;
    expect_bus("R6", 8'h00); send_byte(CR);
    expect_bus("R6", 8'h33); recv_byte(1'b1);
    expect_bus("R10", 8'h44); recv_byte(1'b0);
    bus_stop;
    wq(10);

    chk("R2", "bus items left over", 16'(exp_val_q.size()), 16'd0);
    chk("R6", "writes left over", 16'(wexp_val_q.size()), 16'd0);
    chk("R7", "final commit count", 16'(n_commit), 16'd2);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule